// File: doc/BRIEF.md
# Interrupt Context Switch Sequencer

This block sits next to a small 16-bit processor core. It performs the multi-cycle context switch when the core accepts an interrupt or an exception, and it performs the matching return when the core executes a return-from-interrupt. On entry it moves the machine into supervisor mode. It swaps stack pointers if the core was running in user mode, saves the status word and the program counter on the supervisor stack, and fetches the handler address from a 256-entry vector table. On return it pops both words back and swaps the stack pointers again when the restored status says user mode.

The core hands over its current PC, status word and stack pointer (R6) with a single-cycle request. It then waits for a one-cycle completion pulse, after which the new PC, status word and R6 are valid on the outputs. All stack and vector-table traffic goes through one memory port that uses a request/acknowledge handshake. The block keeps the stack pointer that is not in use in two internal shadow registers, one for user and one for supervisor.

Top module: `irq_ctx_seq`

## Requirements
- R1: After a synchronous active-low reset, `new_pc`, `new_psr` and `new_sp` are 0, `done` and `mem_req` are low, and the supervisor shadow pointer holds `SSP_RESET` (0x3000 by default).
- R2: On an entry request the stack base depends on the mode. When `cur_psr[15]` is 1 (user), `cur_sp` is stored as the saved user pointer and the base is the saved supervisor pointer. When `cur_psr[15]` is 0 (supervisor), the base is `cur_sp` and neither shadow register changes.
- R3: Entry writes exactly two words, in this order: `cur_psr` at base−1, then `cur_pc` at base−2.
- R4: After the two pushes, entry reads address 0x0100 + `ent_vec`. Vectors 0x00–0x7F land in the exception range 0x0100–0x017F and vectors 0x80–0xFF land in the interrupt range 0x0180–0x01FF. `new_pc` takes the word that was read.
- R5: The status word after entry equals `cur_psr` with bit 15 cleared, bits 10:8 replaced by `ent_prio`, and bits 2:0 (N, Z, P) cleared. All other bits are unchanged.
- R6: After entry, `new_sp` equals base−2.
- R7: On a return request the block reads the PC at `cur_sp` and then the status word at `cur_sp`+1, with no writes. `new_pc` and `new_psr` take the two words read.
- R8: On return, if the popped status word has bit 15 set, the block stores `cur_sp`+2 as the saved supervisor pointer and `new_sp` takes the saved user pointer. Otherwise `new_sp` is `cur_sp`+2 and neither shadow register changes.
- R9: `done` is high for exactly one cycle per operation, in the first cycle the new outputs are valid. The outputs then hold until the next operation completes.
- R10: `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack` is sampled high. Each acknowledge completes one access.
- R11: Requests that arrive while an operation is in progress are ignored. If an entry request and a return request arrive in the same idle cycle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_req | input | 1 | Single-cycle strobe: start interrupt/exception entry |
| ent_vec | input | 8 | Vector number selecting the table entry |
| ent_prio | input | 3 | Priority level to install on entry |
| rti_req | input | 1 | Single-cycle strobe: start return from interrupt |
| cur_pc | input | 16 | Current program counter |
| cur_psr | input | 16 | Current status word |
| cur_sp | input | 16 | Current R6 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| new_pc | output | 16 | PC after the operation |
| new_psr | output | 16 | Status word after the operation |
| new_sp | output | 16 | R6 after the operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the stack-pointer swap from both sides. If the block swapped on a supervisor-mode entry, or failed to swap on a return to user mode, a later round trip would come back with the wrong R6 or would push to the wrong stack. Vectors at the edges of the two table halves (0x00, 0x7F, 0x80, 0xFF) show whether the table address is off or truncated. Checking the order of the pushes and pops catches a design that swapped PC and PSR on the stack. Requests injected mid-sequence, and entry and return arriving together, show whether a busy design restarts, starts a second operation or picks the wrong one.

// File: rtl/irq_seq_pkg.sv
// Package: shared sequencer state encoding and status-word field positions.
// Assumes a 16-bit status word with privilege at the top bit, priority at 10:8,
// and condition codes at 2:0.
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_POP_PC,
        ST_POP_PSR
    } seq_state_e;

    localparam int PRIO_LO = 8;
    localparam int CC_W    = 3;
endpackage

// File: rtl/irq_psr_entry.sv
// Module: builds the status word installed on entry.
// Clears privilege (supervisor), installs the new priority and clears the
// condition codes. All other bits pass through unchanged. Purely combinational.
module irq_psr_entry
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PRIO_W = 3
) (
    input  logic [DATA_W-1:0] psr_in,
    input  logic [PRIO_W-1:0] prio_in,
    output logic [DATA_W-1:0] psr_out
);
    localparam int PRIV_BIT = DATA_W - 1;

    // Field rewrite of the saved status word.
    always_comb begin
        psr_out                      = psr_in;
        psr_out[PRIV_BIT]            = 1'b0;
        psr_out[PRIO_LO +: PRIO_W]   = prio_in;
        psr_out[CC_W-1:0]            = '0;
    end
endmodule

// File: rtl/irq_sp_shadow.sv
// Module: the two shadow stack-pointer registers (saved user, saved supervisor).
// Assumes the sequencer never writes both in the same cycle.
module irq_sp_shadow #(
    parameter int          DATA_W    = 16,
    parameter logic [15:0] SSP_RESET = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usp_we,
    input  logic [DATA_W-1:0] usp_d,
    input  logic              ssp_we,
    input  logic [DATA_W-1:0] ssp_d,
    output logic [DATA_W-1:0] usp_q,
    output logic [DATA_W-1:0] ssp_q
);
    // Shadow register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usp_q <= '0;
            ssp_q <= DATA_W'(SSP_RESET);
        end else begin
            if (usp_we) usp_q <= usp_d;
            if (ssp_we) ssp_q <= ssp_d;
        end
    end

    // R2/R8: an entry swap and a return swap never coincide.
    a_r2_swap_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(usp_we && ssp_we));
endmodule

// File: rtl/irq_seq_ctrl.sv
// Module: state machine for entry (push PSR, push PC, vector fetch) and
// return (pop PC, pop PSR). Drives the memory port and the shadow writes.
// Assumes VEC_BASE is aligned to 2**VEC_W and that the memory returns
// read data together with mem_ack.
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          VEC_W    = 8,
    parameter int          PRIO_W   = 3,
    parameter logic [15:0] VEC_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_req,
    input  logic [VEC_W-1:0]  ent_vec,
    input  logic [PRIO_W-1:0] ent_prio,
    input  logic              rti_req,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [DATA_W-1:0] cur_psr,
    input  logic [DATA_W-1:0] cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] usp_q,
    input  logic [DATA_W-1:0] ssp_q,
    output logic              usp_we,
    output logic [DATA_W-1:0] usp_d,
    output logic              ssp_we,
    output logic [DATA_W-1:0] ssp_d,
    output logic [DATA_W-1:0] psr_lat,
    output logic [PRIO_W-1:0] prio_lat,
    input  logic [DATA_W-1:0] entry_psr,
    output logic [DATA_W-1:0] new_pc,
    output logic [DATA_W-1:0] new_psr,
    output logic [DATA_W-1:0] new_sp,
    output logic              done
);
    localparam int          PRIV_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] VBASE = DATA_W'(VEC_BASE);

    seq_state_e        state;
    logic [DATA_W-1:0] pc_lat;
    logic [VEC_W-1:0]  vec_lat;
    logic [DATA_W-1:0] sp_w;
    logic              op_entry;
    logic [DATA_W-1:0] vec_addr;
    logic              user_entry;

    assign vec_addr   = VBASE + {{(DATA_W-VEC_W){1'b0}}, vec_lat};
    assign user_entry = (state == ST_IDLE) && ent_req && cur_psr[PRIV_BIT];

    // Shadow writes: save user SP on user entry, save supervisor SP on return to user.
    always_comb begin
        usp_we = user_entry;
        usp_d  = cur_sp;
        ssp_we = (state == ST_POP_PSR) && mem_ack && mem_rdata[PRIV_BIT];
        ssp_d  = sp_w + DATA_W'(1);
    end

    // Memory port drive per state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = sp_w;
        mem_wdata = psr_lat;
        case (state)
            ST_IDLE:     mem_req = 1'b0;
            ST_PUSH_PSR: mem_we  = 1'b1;
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_wdata = pc_lat;
            end
            ST_VEC_RD:   mem_addr = vec_addr;
            default: ;
        endcase
    end

    // Sequencer state, latched context and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pc_lat   <= '0;
            psr_lat  <= '0;
            vec_lat  <= '0;
            prio_lat <= '0;
            sp_w     <= '0;
            op_entry <= 1'b0;
            new_pc   <= '0;
            new_psr  <= '0;
            new_sp   <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ent_req) begin
                        pc_lat   <= cur_pc;
                        psr_lat  <= cur_psr;
                        vec_lat  <= ent_vec;
                        prio_lat <= ent_prio;
                        sp_w     <= (cur_psr[PRIV_BIT] ? ssp_q : cur_sp) - DATA_W'(1);
                        op_entry <= 1'b1;
                        state    <= ST_PUSH_PSR;
                    end else if (rti_req) begin
                        sp_w     <= cur_sp;
                        op_entry <= 1'b0;
                        state    <= ST_POP_PC;
                    end
                end
                ST_PUSH_PSR: if (mem_ack) begin
                    sp_w  <= sp_w - DATA_W'(1);
                    state <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (mem_ack) state <= ST_VEC_RD;
                ST_VEC_RD: if (mem_ack) begin
                    new_pc  <= mem_rdata;
                    new_psr <= entry_psr;
                    new_sp  <= sp_w;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                ST_POP_PC: if (mem_ack) begin
                    pc_lat <= mem_rdata;
                    sp_w   <= sp_w + DATA_W'(1);
                    state  <= ST_POP_PSR;
                end
                ST_POP_PSR: if (mem_ack) begin
                    new_pc  <= pc_lat;
                    new_psr <= mem_rdata;
                    new_sp  <= mem_rdata[PRIV_BIT] ? usp_q : sp_w + DATA_W'(1);
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: a pending access holds its request and payload until acknowledged.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));

    // R9: completion is a single-cycle pulse.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: an entry always completes in supervisor mode with clear condition codes.
    a_r5_entry_psr: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_entry) |-> (!new_psr[PRIV_BIT] && new_psr[CC_W-1:0] == '0));

    // R4: the vector fetch stays inside the table window.
    a_r4_vec_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && state == ST_VEC_RD)
            |-> (mem_addr[DATA_W-1:VEC_W] == VBASE[DATA_W-1:VEC_W]));

    // R7: a return never writes memory.
    a_r7_pop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_entry && mem_req) |-> !mem_we);
endmodule

// File: rtl/irq_ctx_seq.sv
// Module: top of the interrupt context switch sequencer. Connects the control
// state machine, the entry status-word formatter and the shadow stack pointers.
// Assumes single-cycle request strobes and a handshaked word-wide memory port.
module irq_ctx_seq #(
    parameter int          DATA_W    = 16,
    parameter int          VEC_W     = 8,
    parameter int          PRIO_W    = 3,
    parameter logic [15:0] VEC_BASE  = 16'h0100,
    parameter logic [15:0] SSP_RESET = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_req,
    input  logic [VEC_W-1:0]  ent_vec,
    input  logic [PRIO_W-1:0] ent_prio,
    input  logic              rti_req,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [DATA_W-1:0] cur_psr,
    input  logic [DATA_W-1:0] cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] new_pc,
    output logic [DATA_W-1:0] new_psr,
    output logic [DATA_W-1:0] new_sp,
    output logic              done
);
    logic              usp_we, ssp_we;
    logic [DATA_W-1:0] usp_d, ssp_d, usp_q, ssp_q;
    logic [DATA_W-1:0] psr_lat, entry_psr;
    logic [PRIO_W-1:0] prio_lat;

    irq_seq_ctrl #(
        .DATA_W(DATA_W), .VEC_W(VEC_W), .PRIO_W(PRIO_W), .VEC_BASE(VEC_BASE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ent_req(ent_req), .ent_vec(ent_vec), .ent_prio(ent_prio), .rti_req(rti_req),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .usp_q(usp_q), .ssp_q(ssp_q),
        .usp_we(usp_we), .usp_d(usp_d), .ssp_we(ssp_we), .ssp_d(ssp_d),
        .psr_lat(psr_lat), .prio_lat(prio_lat), .entry_psr(entry_psr),
        .new_pc(new_pc), .new_psr(new_psr), .new_sp(new_sp), .done(done)
    );

    irq_psr_entry #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_psr (
        .psr_in(psr_lat), .prio_in(prio_lat), .psr_out(entry_psr)
    );

    irq_sp_shadow #(.DATA_W(DATA_W), .SSP_RESET(SSP_RESET)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .usp_we(usp_we), .usp_d(usp_d), .ssp_we(ssp_we), .ssp_d(ssp_d),
        .usp_q(usp_q), .ssp_q(ssp_q)
    );
endmodule

// File: tb/sim_irq_ctx_seq.sv
// Bench: directed corner cases plus seeded random round trips, checked against
// a bench-side model of the shadow pointers and a bench-owned memory.
module sim_irq_ctx_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_req = 1'b0, rti_req = 1'b0;
    logic [7:0]  ent_vec = '0;
    logic [2:0]  ent_prio = '0;
    logic [15:0] cur_pc = '0, cur_psr = '0, cur_sp = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [15:0] new_pc, new_psr, new_sp;
    logic        done;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [15:0] m_usp = 16'h0000, m_ssp = 16'h3000;

    logic [15:0] mem [logic [15:0]];
    logic [15:0] wr_addr [256];
    logic [15:0] wr_data [256];
    logic [15:0] rd_addr [256];
    int wr_n = 0, rd_n = 0, acc_wait = 0, hold_err = 0;
    logic        ack_d = 1'b0;
    logic [15:0] hold_addr = '0, hold_data = '0;
    logic        hold_valid = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_ctx_seq u0 (
        .clk(clk), .rst_n(rst_n), .ent_req(ent_req), .ent_vec(ent_vec), .ent_prio(ent_prio),
        .rti_req(rti_req), .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .new_pc(new_pc), .new_psr(new_psr), .new_sp(new_sp), .done(done)
    );

    function automatic logic [15:0] vec_word(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return 16'hDEAD;
    endfunction

    function automatic logic [15:0] entry_psr_exp(input logic [15:0] p, input logic [2:0] pr);
        logic [15:0] e = p;
        e[15] = 1'b0;
        e[10:8] = pr;
        e[2:0] = 3'b000;
        return e;
    endfunction

    // Memory model: random acknowledge latency, logs every access.
    always @(negedge clk) begin
        if (ack_d) begin
            ack_d = 1'b0;
            mem_ack <= 1'b0;
            hold_valid = 1'b0;
        end else if (mem_req) begin
            if (!hold_valid) begin
                hold_valid = 1'b1;
                hold_addr = mem_addr;
                hold_data = mem_wdata;
            end else if (hold_addr != mem_addr || (mem_we && hold_data != mem_wdata)) begin
                hold_err++;
            end
            if (acc_wait == 0) begin
                ack_d = 1'b1;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_addr[wr_n % 256] = mem_addr;
                    wr_data[wr_n % 256] = mem_wdata;
                    wr_n++;
                end else begin
                    mem_rdata <= mem_rd(mem_addr);
                    rd_addr[rd_n % 256] = mem_addr;
                    rd_n++;
                end
                acc_wait = $urandom % 3;
            end else begin
                acc_wait--;
            end
        end
    end

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic wait_done();
        int cnt = 0;
        while (done !== 1'b1 && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        chk("R9 done seen", {15'd0, done}, 16'd1);
    endtask

    // Entry; poke injects extra requests while busy, both raises rti_req too.
    task automatic do_entry(input logic [15:0] pc, input logic [15:0] psr, input logic [15:0] sp,
                            input logic [7:0] vec, input logic [2:0] pr, input bit poke,
                            input bit both, output logic [15:0] sp_out);
        int w0, r0;
        logic [15:0] base;
        base = psr[15] ? m_ssp : sp;
        @(negedge clk);
        w0 = wr_n; r0 = rd_n;
        cur_pc = pc; cur_psr = psr; cur_sp = sp; ent_vec = vec; ent_prio = pr;
        ent_req = 1'b1; rti_req = both;
        @(negedge clk);
        ent_req = 1'b0; rti_req = 1'b0;
        cur_pc = ~pc; cur_psr = ~psr; cur_sp = ~sp; ent_vec = ~vec; ent_prio = ~pr;
        if (psr[15]) m_usp = sp;
        if (poke) begin
            @(negedge clk);
            ent_req = 1'b1; rti_req = 1'b1;
            @(negedge clk);
            ent_req = 1'b0; rti_req = 1'b0;
        end
        wait_done();
        chk("R3 write count", 16'(wr_n - w0), 16'd2);
        chk("R3 first write addr (PSR)", wr_addr[w0 % 256], base - 16'd1);
        chk("R3 first write data (PSR)", wr_data[w0 % 256], psr);
        chk("R3 second write addr (PC)", wr_addr[(w0 + 1) % 256], base - 16'd2);
        chk("R3 second write data (PC)", wr_data[(w0 + 1) % 256], pc);
        chk("R4 vector read addr", rd_addr[r0 % 256], 16'h0100 + {8'h00, vec});
        chk("R4 new_pc from table", new_pc, vec_word(16'h0100 + {8'h00, vec}));
        chk("R5 entry psr", new_psr, entry_psr_exp(psr, pr));
        chk("R6 R2 entry sp", new_sp, base - 16'd2);
        sp_out = new_sp;
        @(negedge clk);
        chk("R9 done single cycle", {15'd0, done}, 16'd0);
        chk("R9 outputs hold", new_sp, base - 16'd2);
    endtask

    task automatic do_rti(input logic [15:0] sp, output logic [15:0] pc_o,
                          output logic [15:0] psr_o, output logic [15:0] sp_o);
        int w0, r0;
        logic [15:0] epc, epsr, esp;
        epc = mem_rd(sp);
        epsr = mem_rd(sp + 16'd1);
        esp = epsr[15] ? m_usp : sp + 16'd2;
        @(negedge clk);
        w0 = wr_n; r0 = rd_n;
        cur_sp = sp; rti_req = 1'b1;
        @(negedge clk);
        rti_req = 1'b0; cur_sp = ~sp;
        if (epsr[15]) m_ssp = sp + 16'd2;
        wait_done();
        chk("R7 no writes on return", 16'(wr_n - w0), 16'd0);
        chk("R7 pop PC addr first", rd_addr[r0 % 256], sp);
        chk("R7 pop PSR addr second", rd_addr[(r0 + 1) % 256], sp + 16'd1);
        chk("R7 new_pc", new_pc, epc);
        chk("R7 new_psr", new_psr, epsr);
        chk("R8 return sp", new_sp, esp);
        pc_o = new_pc; psr_o = new_psr; sp_o = new_sp;
        @(negedge clk);
        chk("R9 done single cycle (return)", {15'd0, done}, 16'd0);
    endtask

    // Entry followed by the matching return; the context must come back intact.
    task automatic round_trip(input logic [15:0] pc, input logic [15:0] psr, input logic [15:0] sp,
                              input logic [7:0] vec, input logic [2:0] pr);
        logic [15:0] s1, rp, rps, rs;
        do_entry(pc, psr, sp, vec, pr, 1'b0, 1'b0, s1);
        do_rti(s1, rp, rps, rs);
        chk("R8 round trip pc", rp, pc);
        chk("R8 round trip psr", rps, psr);
        chk("R8 R2 round trip sp", rs, sp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        summary();
    end

    initial begin
        logic [15:0] s1, s2, rp, rps, rs;
        void'($urandom(32'd20240917));
        for (int i = 0; i < 256; i++)
            mem[16'h0100 + 16'(i)] = vec_word(16'h0100 + 16'(i));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 new_pc reset", new_pc, 16'h0);
        chk("R1 new_psr reset", new_psr, 16'h0);
        chk("R1 new_sp reset", new_sp, 16'h0);
        chk("R1 done/mem_req reset", {14'd0, done, mem_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2: first user entry uses the reset supervisor pointer 0x3000
        round_trip(16'h4321, 16'h8207, 16'h8000, 8'h00, 3'd4);
        // R4 table edges, entered from supervisor mode (no swap)
        round_trip(16'h1111, 16'h0102, 16'h2F00, 8'h7F, 3'd7);
        round_trip(16'h2222, 16'h0001, 16'h2E00, 8'h80, 3'd1);
        round_trip(16'h3333, 16'h0704, 16'h2D00, 8'hFF, 3'd0);
        // Nested: user entry then supervisor entry, unwound in reverse
        do_entry(16'hA000, 16'h8302, 16'h9000, 8'h81, 3'd3, 1'b0, 1'b0, s1);
        do_entry(16'hB000, 16'h0300, s1, 8'h05, 3'd6, 1'b0, 1'b0, s2);
        do_rti(s2, rp, rps, rs);
        chk("R8 nested inner sp", rs, s1);
        do_rti(rs, rp, rps, rs);
        chk("R8 nested outer sp", rs, 16'h9000);
        chk("R8 nested outer pc", rp, 16'hA000);
        // R11: requests while busy are ignored
        do_entry(16'h5555, 16'h8001, 16'h8800, 8'h90, 3'd2, 1'b1, 1'b0, s1);
        repeat (6) begin
            @(negedge clk);
            chk("R11 no extra access", {15'd0, mem_req}, 16'd0);
        end
        do_rti(s1, rp, rps, rs);
        chk("R11 busy return sp", rs, 16'h8800);
        // R11: simultaneous entry and return, entry wins
        do_entry(16'h6666, 16'h0000, 16'h2C00, 8'h33, 3'd5, 1'b0, 1'b1, s1);
        do_rti(s1, rp, rps, rs);
        // R8: return to supervisor frame leaves shadows untouched
        mem[16'h2A00] = 16'h7777;
        mem[16'h2A01] = 16'h0405;
        do_rti(16'h2A00, rp, rps, rs);
        chk("R8 supervisor return sp", rs, 16'h2A02);
        // Random round trips
        for (int i = 0; i < 40; i++) begin
            logic [15:0] pc, psr, sp;
            pc = 16'($urandom);
            psr = 16'($urandom);
            if (psr[15]) sp = 16'h8000 + 16'($urandom % 16'h7000);
            else sp = 16'h2000 + 16'($urandom % 16'h0E00);
            round_trip(pc, psr, sp, 8'($urandom), 3'($urandom));
        end
        chk("R10 request held until ack", 16'(hold_err), 16'd0);
        summary();
    end
endmodule